// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter with PWM

This block holds two byte-oriented timer/counters that share one mode register. Each has a low count byte, a high count byte, a run enable, a select between timing (one step per machine cycle) and counting (one step per falling edge of its own count input), an enable that makes its output pin toggle on overflow, and an overflow flag. A machine cycle is `CLK_PER_MC` clocks long, and a single strobe derived from the clock paces both units.

Five operating modes are offered per unit: a 13-bit count behind a divide-by-32 prescaler, a full 16-bit count, an 8-bit count with automatic reload, a split mode in which unit 0 becomes two independent 8-bit counters (and unit 1 stops), and a PWM mode with a 256-step period whose duty is set by the high byte. Software reaches every register through a simple synchronous-write, combinational-read register bus.

Register map (byte addresses): 0 control = {0, tog1, sel1, run1, 0, tog0, sel0, run0}; 1 mode = {0, mode1[2:0], 0, mode0[2:0]}; 2 LO0; 3 HI0; 4 LO1; 5 HI1; 6 flags = {000000, ovf1, ovf0}; 7 reads 0. Mode codes: 0 = 13-bit, 1 = 16-bit, 2 = reload, 3 = split, 6 = PWM.

Top module: `tmr_pair`

## Requirements
- R1: After reset all registers read 0 (addresses 0 to 6) and both pins are 0.
- R2: With run=1 and sel=0 a unit advances exactly once every `CLK_PER_MC` clocks; with run=0 it holds.
- R3: With sel=1 a unit advances at a machine-cycle strobe where the input sampled at the previous strobe was 1 and the input now is 0; a low level shorter than one machine cycle may be missed.
- R4: Mode 0 counts {HI, LO[4:0]} as 13 bits, LO[7:5] stay unchanged, and overflow occurs when HI=FFh and LO[4:0]=1Fh step.
- R5: Mode 1 counts {HI, LO} as 16 bits and overflows from FFFFh to 0000h.
- R6: Mode 2 increments LO; a step from LO=FFh loads LO with HI and overflows.
- R7: In mode 3 unit 0's LO counts under unit 0's run/sel and sets ovf0; HI0 counts machine cycles when run1=1 and sets ovf1 on FFh; unit 1 in mode 3 holds its count.
- R8: In mode 6 LO wraps every 256 steps and sets the flag at the wrap; the pin is 1 while LO < HI and 0 otherwise, and no toggle occurs.
- R9: In modes 0 to 3 an overflow with tog=1 inverts the pin on the next clock; with tog=0 the pin holds.
- R10: A flag is set in the clock after the overflow step; a bus write to address 6 clears each flag whose written bit is 0 and leaves those written 1; a simultaneous overflow wins.
- R11: A bus write to a count byte replaces that byte on the same edge, overriding the step; reads return the map above.
- R12: Mode codes 4, 5 and 7 hold both count bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 3 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| cnt_in_i | input | 2 | External count inputs, bit n for unit n |
| tmr_pin_o | output | 2 | Toggle/PWM output pins, bit n for unit n |

## Verification
On every cycle the assertions check the strobe spacing, that edges are only seen on a strobe with the input low, the mode-2 reload value, the 16-bit wrap, pin inversion after an enabled overflow, the stop of unit 1 in split mode and of undefined modes, and that flags set after an overflow and stay until cleared. Only the bench scenarios show whole-mode behaviour against the reference: prescaler carries in mode 0, missed short pulses in counting, PWM duty over a full period, the split timer's two flags, and bus writes colliding with count steps.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int PRE_W  = 5;
  localparam int MODE_W = 3;
  localparam int NUM_T  = 2;

  typedef enum logic [MODE_W-1:0] {
    MD_13B    = 3'd0,
    MD_16B    = 3'd1,
    MD_RELOAD = 3'd2,
    MD_SPLIT  = 3'd3,
    MD_PWM    = 3'd6
  } tmr_mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_HI0  = 3'd3;
  localparam logic [ADDR_W-1:0] A_LO1  = 3'd4;
  localparam logic [ADDR_W-1:0] A_HI1  = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd6;
endpackage

// File: rtl/tmr_mc_tick.sv
module tmr_mc_tick #(
  parameter int CLK_PER_MC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CLK_PER_MC <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLK_PER_MC);
      localparam logic [CW-1:0] LAST = CW'(CLK_PER_MC - 1);
      logic [CW-1:0] cnt_q;

      assign tick_o = (cnt_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end

      // R2: strobes never adjacent
      a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tmr_fall_det.sv
module tmr_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ext_i,
  output logic fall_o
);
  logic samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     samp_q <= 1'b0;
    else if (tick_i) samp_q <= ext_i;
  end

  assign fall_o = tick_i & samp_q & ~ext_i;

  // R3: edge only reported on a strobe with the input low
  a_r3_fall_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (tick_i && !ext_i));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter bit IS_T0 = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              cnt_en_i,
  input  logic              hi_en_i,
  input  logic              tog_en_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_o,
  output logic              hi_ovf_o,
  output logic              pin_o
);
  localparam int W13 = BYTE_W + PRE_W;
  localparam int W16 = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic              ovf, hovf, tog_q;
  logic [W13-1:0]    c13;
  logic [W16-1:0]    c16;
  logic              is_pwm;

  assign is_pwm = (mode_i == MD_PWM);

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    ovf  = 1'b0;
    hovf = 1'b0;
    c13  = {hi_q, lo_q[PRE_W-1:0]} + W13'(1);
    c16  = {hi_q, lo_q} + W16'(1);
    case (mode_i)
      MD_13B: if (cnt_en_i) begin
        {hi_d, lo_d[PRE_W-1:0]} = c13;
        ovf = &{hi_q, lo_q[PRE_W-1:0]};
      end
      MD_16B: if (cnt_en_i) begin
        {hi_d, lo_d} = c16;
        ovf = &{hi_q, lo_q};
      end
      MD_RELOAD: if (cnt_en_i) begin
        if (&lo_q) begin
          lo_d = hi_q;
          ovf  = 1'b1;
        end else begin
          lo_d = lo_q + 1'b1;
        end
      end
      MD_SPLIT: if (IS_T0) begin
        if (cnt_en_i) begin
          lo_d = lo_q + 1'b1;
          ovf  = &lo_q;
        end
        if (hi_en_i) begin
          hi_d = hi_q + 1'b1;
          hovf = &hi_q;
        end
      end
      MD_PWM: if (cnt_en_i) begin
        lo_d = lo_q + 1'b1;
        ovf  = &lo_q;
      end
      default: ;
    endcase
    if (wr_lo_i) lo_d = wdata_i;
    if (wr_hi_i) hi_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      tog_q <= 1'b0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      tog_q <= tog_q ^ (ovf & tog_en_i & ~is_pwm);
    end
  end

  assign lo_o     = lo_q;
  assign hi_o     = hi_q;
  assign ovf_o    = ovf;
  assign hi_ovf_o = hovf;
  assign pin_o    = is_pwm ? (lo_q < hi_q) : tog_q;

  a_r6_reload_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_RELOAD && cnt_en_i && &lo_q && !wr_lo_i && !wr_hi_i)
      |=> (lo_q == $past(hi_q)));

  a_r5_wrap16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_16B && cnt_en_i && &{hi_q, lo_q} && !wr_lo_i && !wr_hi_i)
      |=> (lo_q == '0 && hi_q == '0));

  a_r9_pin_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && tog_en_i && !is_pwm) |=> (tog_q != $past(tog_q)));

  a_r12_undef_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 3'd4 || mode_i == 3'd5 || mode_i == 3'd7) && !wr_lo_i && !wr_hi_i)
      |=> ($stable(lo_q) && $stable(hi_q)));

  generate
    if (!IS_T0) begin : g_t1_chk
      a_r7_t1_split_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MD_SPLIT && !wr_lo_i && !wr_hi_i)
          |=> ($stable(lo_q) && $stable(hi_q)));
    end
  endgenerate
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int CLK_PER_MC = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  input  logic [NUM_T-1:0]  cnt_in_i,
  output logic [NUM_T-1:0]  tmr_pin_o
);
  logic                          tick;
  logic [NUM_T-1:0]              run_q, sel_q, tog_q, fall, ovf, hovf;
  logic [NUM_T-1:0]              flag_q, flag_set, flag_mask;
  logic [NUM_T-1:0][MODE_W-1:0]  mode_q;
  logic [NUM_T-1:0][BYTE_W-1:0]  lo, hi;
  logic [NUM_T-1:0][BYTE_W-1:0]  ctrl_nib;

  tmr_mc_tick #(.CLK_PER_MC(CLK_PER_MC)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar g = 0; g < NUM_T; g++) begin : g_unit
    localparam logic [ADDR_W-1:0] ALO = A_LO0 + ADDR_W'(2 * g);
    localparam logic [ADDR_W-1:0] AHI = A_HI0 + ADDR_W'(2 * g);
    logic cnt_en;

    tmr_fall_det i_fall (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick),
      .ext_i (cnt_in_i[g]),
      .fall_o(fall[g])
    );

    assign cnt_en = run_q[g] & (sel_q[g] ? fall[g] : tick);

    tmr_core #(.IS_T0(g == 0)) i_core (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mode_i  (mode_q[g]),
      .cnt_en_i(cnt_en),
      .hi_en_i (run_q[NUM_T-1] & tick),
      .tog_en_i(tog_q[g]),
      .wr_lo_i (bus_we_i && bus_addr_i == ALO),
      .wr_hi_i (bus_we_i && bus_addr_i == AHI),
      .wdata_i (bus_wdata_i),
      .lo_o    (lo[g]),
      .hi_o    (hi[g]),
      .ovf_o   (ovf[g]),
      .hi_ovf_o(hovf[g]),
      .pin_o   (tmr_pin_o[g])
    );

    assign ctrl_nib[g] = BYTE_W'({tog_q[g], sel_q[g], run_q[g]});
  end

  // split-mode high byte of unit 0 reports through unit 1's flag
  assign flag_set  = ovf | {hovf[0], 1'b0};
  assign flag_mask = (bus_we_i && bus_addr_i == A_FLAG) ? bus_wdata_i[NUM_T-1:0] : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      sel_q  <= '0;
      tog_q  <= '0;
      mode_q <= '0;
      flag_q <= '0;
    end else begin
      flag_q <= (flag_q & flag_mask) | flag_set;
      if (bus_we_i && bus_addr_i == A_CTRL) begin
        for (int t = 0; t < NUM_T; t++) begin
          run_q[t] <= bus_wdata_i[4*t];
          sel_q[t] <= bus_wdata_i[4*t+1];
          tog_q[t] <= bus_wdata_i[4*t+2];
        end
      end
      if (bus_we_i && bus_addr_i == A_MODE) begin
        for (int t = 0; t < NUM_T; t++)
          mode_q[t] <= bus_wdata_i[4*t +: MODE_W];
      end
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_CTRL:  bus_rdata_o = ctrl_nib[0] | (ctrl_nib[1] << 4);
      A_MODE:  bus_rdata_o = BYTE_W'(mode_q[0]) | (BYTE_W'(mode_q[1]) << 4);
      A_LO0:   bus_rdata_o = lo[0];
      A_HI0:   bus_rdata_o = hi[0];
      A_LO1:   bus_rdata_o = lo[1];
      A_HI1:   bus_rdata_o = hi[1];
      A_FLAG:  bus_rdata_o = BYTE_W'(flag_q);
      default: bus_rdata_o = '0;
    endcase
  end

  a_r10_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf[0] |=> flag_q[0]);

  a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[1] && !(bus_we_i && bus_addr_i == A_FLAG)) |=> flag_q[1]);
endmodule

// File: tb/test_tmr_pair.sv
module test_tmr_pair;
  localparam int N = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic [1:0] ext = '0;
  logic [1:0] pins;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  tmr_pair #(.CLK_PER_MC(N)) i_tmr_pair (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wd), .bus_rdata_o(rdata), .cnt_in_i(ext), .tmr_pin_o(pins)
  );

  // reference model
  int m_lo[2], m_hi[2], m_mode[2];
  bit m_run[2], m_sel[2], m_tog[2], m_tq[2], m_f[2], m_smp[2];
  int m_pc;
  int nl[2], nh[2], v;
  bit tk, hov, en[2], ov[2], msk[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin
        m_lo[t] = 0; m_hi[t] = 0; m_mode[t] = 0; m_run[t] = 0; m_sel[t] = 0;
        m_tog[t] = 0; m_tq[t] = 0; m_f[t] = 0; m_smp[t] = 0;
      end
      m_pc = 0;
    end else begin
      tk = (m_pc == N - 1);
      hov = 0;
      for (int t = 0; t < 2; t++) begin
        en[t] = m_run[t] && (m_sel[t] ? (tk && m_smp[t] && !ext[t]) : tk);
        ov[t] = 0; nl[t] = m_lo[t]; nh[t] = m_hi[t];
        case (m_mode[t])
          0: if (en[t]) begin
            v = m_hi[t] * 32 + m_lo[t] % 32 + 1;
            if (v == 8192) begin ov[t] = 1; v = 0; end
            nl[t] = (m_lo[t] & 224) | (v % 32); nh[t] = v / 32;
          end
          1: if (en[t]) begin
            v = m_hi[t] * 256 + m_lo[t] + 1;
            if (v == 65536) begin ov[t] = 1; v = 0; end
            nl[t] = v % 256; nh[t] = v / 256;
          end
          2: if (en[t]) begin
            if (m_lo[t] == 255) begin ov[t] = 1; nl[t] = m_hi[t]; end
            else nl[t] = m_lo[t] + 1;
          end
          3: if (t == 0) begin
            if (en[0]) begin ov[0] = (m_lo[0] == 255); nl[0] = (m_lo[0] + 1) % 256; end
            if (m_run[1] && tk) begin hov = (m_hi[0] == 255); nh[0] = (m_hi[0] + 1) % 256; end
          end
          6: if (en[t]) begin ov[t] = (m_lo[t] == 255); nl[t] = (m_lo[t] + 1) % 256; end
          default: ;
        endcase
        if (ov[t] && m_tog[t] && m_mode[t] != 6) m_tq[t] = !m_tq[t];
      end
      msk[0] = 1; msk[1] = 1;
      if (we) begin
        case (addr)
          0: for (int t = 0; t < 2; t++) begin
               m_run[t] = wd[4*t]; m_sel[t] = wd[4*t+1]; m_tog[t] = wd[4*t+2];
             end
          1: begin m_mode[0] = wd[2:0]; m_mode[1] = wd[6:4]; end
          2: nl[0] = wd;
          3: nh[0] = wd;
          4: nl[1] = wd;
          5: nh[1] = wd;
          6: begin msk[0] = wd[0]; msk[1] = wd[1]; end
          default: ;
        endcase
      end
      m_f[0] = (m_f[0] && msk[0]) || ov[0];
      m_f[1] = (m_f[1] && msk[1]) || ov[1] || hov;
      for (int t = 0; t < 2; t++) begin
        m_lo[t] = nl[t]; m_hi[t] = nh[t];
        if (tk) m_smp[t] = ext[t];
      end
      m_pc = tk ? 0 : m_pc + 1;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      0: return {1'b0, m_tog[1], m_sel[1], m_run[1], 1'b0, m_tog[0], m_sel[0], m_run[0]};
      1: return {1'b0, 3'(m_mode[1]), 1'b0, 3'(m_mode[0])};
      2: return 8'(m_lo[0]);
      3: return 8'(m_hi[0]);
      4: return 8'(m_lo[1]);
      5: return 8'(m_hi[1]);
      6: return {6'b0, m_f[1], m_f[0]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_pin(input int t);
    return (m_mode[t] == 6) ? (m_lo[t] < m_hi[t]) : m_tq[t];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] er;
      logic [1:0] ep;
      er = exp_rd(addr);
      ep = {exp_pin(1), exp_pin(0)};
      compared++;
      if (rdata !== er || pins !== ep) begin
        mismatched++;
        $display("FAIL %s t=%0t addr=%0d rdata=%h exp=%h pins=%b exp=%b",
                 cur_req, $time, addr, rdata, er, pins, ep);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      we = 0; addr = addr + 3'd1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    we = 1; addr = a; wd = d;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic pulse_in(input int t, input int low_clks, input int high_clks);
    @(posedge clk); #1; ext[t] = 1'b0; addr = addr + 3'd1;
    idle(low_clks - 1);
    @(posedge clk); #1; ext[t] = 1'b1; addr = addr + 3'd1;
    idle(high_clks - 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset values on every register and pin
    for (int a = 0; a < 7; a++) begin
      @(posedge clk); #1; addr = 3'(a); #1;
      compared++;
      if (rdata !== 8'h00 || pins !== 2'b00) begin
        mismatched++;
        $display("FAIL R1 addr=%0d rdata=%h exp=00 pins=%b exp=00", a, rdata, pins);
      end
    end

    cur_req = "R2";  // timing function, run on/off
    wr(1, 8'h11); wr(0, 8'h01); idle(60);
    wr(0, 8'h00); idle(20);

    cur_req = "R11";  // write collides with counting
    wr(0, 8'h01); idle(2); wr(2, 8'h55); wr(3, 8'hAA); idle(10);

    cur_req = "R5";
    wr(2, 8'hF8); wr(3, 8'hFF); wr(0, 8'h05); idle(50);

    cur_req = "R4";
    wr(1, 8'h10); wr(3, 8'hFF); wr(2, 8'hFA); idle(60);

    cur_req = "R6";
    wr(1, 8'h12); wr(3, 8'hFC); wr(2, 8'hFA); idle(80);

    cur_req = "R9";  // toggle disabled
    wr(0, 8'h01); idle(60);

    cur_req = "R10";
    wr(6, 8'h03); idle(3); wr(6, 8'h00); idle(3);
    wr(0, 8'h05); wr(2, 8'hFF); idle(N + 1); wr(6, 8'h02); idle(5);

    cur_req = "R3";  // counter function on both units
    wr(0, 8'h33); wr(1, 8'h12); wr(2, 8'h00); wr(4, 8'hFD); wr(5, 8'h80);
    ext = 2'b11; idle(6);
    for (int k = 0; k < 6; k++) pulse_in(0, 2 * N, 2 * N);
    pulse_in(0, 1, 3 * N);           // narrow low may be missed
    for (int k = 0; k < 5; k++) pulse_in(1, N, N + 1);
    pulse_in(1, N + 2, 1);           // narrow high
    idle(10);

    cur_req = "R7";  // split unit 0, unit 1 stops in mode 3
    wr(0, 8'h15); wr(1, 8'h33); wr(2, 8'hF0); wr(3, 8'hF8); idle(100);
    wr(0, 8'h05); idle(20);

    cur_req = "R8";  // PWM with duty 0x40, then 0
    wr(1, 8'h06); wr(3, 8'h40); wr(2, 8'h00); wr(0, 8'h05); idle(1600);
    wr(3, 8'h00); idle(100);

    cur_req = "R12";
    wr(1, 8'h75); wr(0, 8'h11); idle(40);
    wr(1, 8'h04); idle(20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule